// File: doc/BRIEF.md
# Dispatch Skid Buffer Controller

This block is the per-thread front end of an instruction dispatch stage. Every cycle the rename stage presents a group of up to `DISP_W` instruction slots, each tagged with a thread number and a squashed flag. The block sorts the live slots into one list per thread, keeping slot order, and forwards each thread's instructions to the issue side. At most `DISP_W` instructions per thread leave in a cycle, on registered outputs.

When a thread cannot dispatch, its arrivals go into that thread's skid buffer in order. A thread cannot dispatch while the commit stage asks it to stall, while its issue queue reports full, or while its load/store queue reports full. The block then raises a one-cycle block pulse toward the earlier stages. Once the stall clears, the buffered entries drain ahead of any new arrivals. The upstream block is released with an unblock pulse only when the buffer is empty.

A per-thread squash takes priority over every stall. It empties that thread's buffer and discards the thread's arrivals during a two-step squash sequence.

Top module: `dsp_skid_ctrl`

## Requirements
- R1: While `rst` is high and in the cycle after it, every thread reports status Idle (code 2), no `out_valid` bit is set and no block or unblock pulse is raised.
- R2: A slot is delivered to thread t only when its valid bit is set, its squashed bit is clear and its thread field equals t. Squashed slots are never forwarded. A thread's delivered slots fill its lanes from lane 0 upward, in increasing slot index.
- R3: With no stall and an empty skid buffer, a thread's sorted instructions appear on its lanes one cycle after they are presented. Lane order follows arrival order.
- R4: Any one of `commit_stall[t]`, `iq_full[t]` or `lsq_full[t]` stops all output for thread t in the following cycle. The thread's arrivals of that cycle are appended to its skid buffer and its status becomes Blocked (code 1).
- R5: `block_up[t]` pulses for exactly one cycle when thread t enters Blocked while its upstream was not blocked. It is never high together with `unblock_up[t]`.
- R6: After a stall clears, buffered entries are dispatched oldest first, `DISP_W` per cycle, ahead of new arrivals. Arrivals are queued behind them. The status is Unblocking (code 5) while entries remain.
- R7: `unblock_up[t]` pulses and the status returns to Running (code 0) only in the cycle whose dispatch leaves thread t's skid buffer empty.
- R8: A squash of thread t outranks any stall. It empties the thread's buffer, drops the thread's arrivals and moves to StartSquash (code 3), then Squashing (code 4), then Idle. Arrivals are dropped in every one of those cycles. An unblock pulse accompanies StartSquash if the upstream was blocked.
- R9: A thread's skid buffer holds `SKID_DEPTH` entries without loss. Upstream must stop sending after a block pulse, so the depth must be at least the upstream reaction delay times `DISP_W`.
- R10: A thread that is not blocked and receives nothing reports Idle (code 2). One that dispatched without being blocked reports Running (code 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | DISP_W | Slot holds an instruction |
| in_tid | input | DISP_W*TID_W | Thread number of each slot |
| in_sq | input | DISP_W | Slot was squashed upstream |
| in_inst | input | DISP_W*INST_W | Instruction payload of each slot |
| commit_stall | input | NUM_THR | Stall request from commit, per thread |
| iq_full | input | NUM_THR | Issue queue full, per thread |
| lsq_full | input | NUM_THR | Load/store queue full, per thread |
| squash | input | NUM_THR | Squash request, per thread |
| out_valid | output | NUM_THR*DISP_W | Lane carries a dispatched instruction |
| out_inst | output | NUM_THR*DISP_W*INST_W | Dispatched payload per thread and lane |
| block_up | output | NUM_THR | One-cycle block pulse to earlier stages |
| unblock_up | output | NUM_THR | One-cycle unblock pulse to earlier stages |
| status | output | NUM_THR*3 | Per-thread dispatch status code |

## Verification
The hardest situations to reach from the ports are a buffer filled to exactly its depth and a drain that mixes old buffered entries with fresh arrivals. A squash landing while the upstream is still blocked is equally hard. The stimulus holds a full flag over two full-width groups to fill the buffer, then releases it. It also feeds a new group during an Unblocking cycle, so that one buffered entry and one new entry share a dispatch and the newer arrival must be held back. Another sequence raises a load/store full and then squashes the blocked thread together with a commit stall. The checks that follow confirm that nothing from before the squash reappears.

// File: rtl/dsp_pkg.sv
package dsp_pkg;

  typedef enum logic [2:0] {
    ST_RUN  = 3'd0,
    ST_BLK  = 3'd1,
    ST_IDLE = 3'd2,
    ST_SSQ  = 3'd3,
    ST_SQG  = 3'd4,
    ST_UNB  = 3'd5
  } dsp_state_e;

endpackage

// File: rtl/dsp_sort.sv
module dsp_sort #(
  parameter int NUM_THR = 2,
  parameter int DISP_W  = 2,
  parameter int INST_W  = 8,
  parameter int TID_W   = 1,
  localparam int IN_CW  = $clog2(DISP_W + 1)
) (
  input  logic [DISP_W-1:0]                 in_valid,
  input  logic [DISP_W*TID_W-1:0]           in_tid,
  input  logic [DISP_W-1:0]                 in_sq,
  input  logic [DISP_W*INST_W-1:0]          in_inst,
  output logic [NUM_THR*DISP_W*INST_W-1:0]  thr_inst,
  output logic [NUM_THR*IN_CW-1:0]          thr_cnt
);

  genvar t;
  generate
    for (t = 0; t < NUM_THR; t++) begin : g_thr
      logic [DISP_W*INST_W-1:0] packed_q;
      int                       k;

      always_comb begin
        packed_q = '0;
        k        = 0;
        for (int i = 0; i < DISP_W; i++) begin
          if (in_valid[i] && !in_sq[i] &&
              in_tid[i*TID_W +: TID_W] == TID_W'(t)) begin
            packed_q[k*INST_W +: INST_W] = in_inst[i*INST_W +: INST_W];
            k = k + 1;
          end
        end
      end

      assign thr_inst[t*DISP_W*INST_W +: DISP_W*INST_W] = packed_q;
      assign thr_cnt[t*IN_CW +: IN_CW]                   = IN_CW'(k);
    end
  endgenerate

endmodule

// File: rtl/dsp_lane.sv
module dsp_lane
  import dsp_pkg::*;
#(
  parameter int DISP_W     = 2,
  parameter int INST_W     = 8,
  parameter int SKID_DEPTH = 4,
  localparam int IN_CW     = $clog2(DISP_W + 1),
  localparam int PTR_W     = $clog2(SKID_DEPTH),
  localparam int CNT_W     = $clog2(SKID_DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [DISP_W*INST_W-1:0] inc_inst,
  input  logic [IN_CW-1:0]         inc_cnt,
  input  logic                     stall,
  input  logic                     squash,
  output logic [DISP_W-1:0]        out_valid,
  output logic [DISP_W*INST_W-1:0] out_inst,
  output logic                     block_up,
  output logic                     unblock_up,
  output dsp_state_e               state
);

  logic [INST_W-1:0] mem [SKID_DEPTH];
  logic [PTR_W-1:0]  head_q, head_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              up_blk_q, up_blk_n;
  dsp_state_e        st_q, st_n;

  logic [INST_W-1:0] inc_arr [DISP_W];
  logic [INST_W-1:0] view    [DISP_W];
  logic [DISP_W-1:0] wr_en;
  logic [PTR_W-1:0]  wr_idx  [DISP_W];
  logic              sq_any, go, blk_n, ub_n;
  int                n_in, total, n_pop, rem;

  always_comb begin
    for (int i = 0; i < DISP_W; i++) inc_arr[i] = inc_inst[i*INST_W +: INST_W];
  end

  // Combined queue view: buffered entries first, then this cycle's arrivals.
  always_comb begin
    sq_any = squash || st_q == ST_SSQ || st_q == ST_SQG;
    n_in   = sq_any ? 0 : int'(inc_cnt);
    go     = !stall && !sq_any;
    total  = int'(cnt_q) + n_in;
    n_pop  = go ? ((total < DISP_W) ? total : DISP_W) : 0;
    rem    = total - n_pop;
    for (int j = 0; j < DISP_W; j++) begin
      if (j < int'(cnt_q)) view[j] = mem[PTR_W'(int'(head_q) + j)];
      else                 view[j] = inc_arr[j - int'(cnt_q)];
    end
    for (int i = 0; i < DISP_W; i++) begin
      wr_en[i]  = !sq_any && (i < n_in) && ((int'(cnt_q) + i) >= n_pop);
      wr_idx[i] = PTR_W'(int'(head_q) + int'(cnt_q) + i);
    end
  end

  // Per-thread dispatch state machine; squash outranks every stall.
  always_comb begin
    st_n     = st_q;
    blk_n    = 1'b0;
    ub_n     = 1'b0;
    up_blk_n = up_blk_q;
    cnt_n    = CNT_W'(rem);
    head_n   = PTR_W'(int'(head_q) + n_pop);
    if (squash) begin
      st_n     = ST_SSQ;
      ub_n     = up_blk_q;
      up_blk_n = 1'b0;
      cnt_n    = '0;
    end else begin
      case (st_q)
        ST_SSQ: begin st_n = ST_SQG;  cnt_n = '0; end
        ST_SQG: begin st_n = ST_IDLE; cnt_n = '0; end
        default: begin
          if (stall) begin
            st_n     = ST_BLK;
            blk_n    = !up_blk_q;
            up_blk_n = 1'b1;
          end else if (up_blk_q) begin
            if (rem == 0) begin
              st_n     = ST_RUN;
              ub_n     = 1'b1;
              up_blk_n = 1'b0;
            end else begin
              st_n = ST_UNB;
            end
          end else begin
            st_n = (n_pop > 0) ? ST_RUN : ST_IDLE;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DISP_W; i++) begin
      if (wr_en[i]) mem[wr_idx[i]] <= inc_arr[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      head_q     <= '0;
      up_blk_q   <= 1'b0;
      out_valid  <= '0;
      out_inst   <= '0;
      block_up   <= 1'b0;
      unblock_up <= 1'b0;
    end else begin
      st_q       <= st_n;
      cnt_q      <= cnt_n;
      head_q     <= head_n;
      up_blk_q   <= up_blk_n;
      block_up   <= blk_n;
      unblock_up <= ub_n;
      for (int j = 0; j < DISP_W; j++) begin
        out_valid[j]                 <= (j < n_pop);
        out_inst[j*INST_W +: INST_W] <= view[j];
      end
    end
  end

  assign state = st_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    !sq_any |-> (int'(cnt_q) + int'(inc_cnt)) <= SKID_DEPTH); // R9
  AST_STALL_SILENT: assert property (@(posedge clk) disable iff (rst)
    stall |=> (out_valid == '0)); // R4
  AST_BLOCK_STATE: assert property (@(posedge clk) disable iff (rst)
    block_up |-> (st_q == ST_BLK)); // R5
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(block_up && unblock_up)); // R5
  AST_UNBLOCK_EMPTY: assert property (@(posedge clk) disable iff (rst)
    unblock_up |-> (cnt_q == '0)); // R7
  AST_SQUASH_FLUSH: assert property (@(posedge clk) disable iff (rst)
    squash |=> (cnt_q == '0 && st_q == ST_SSQ && out_valid == '0)); // R8

endmodule

// File: rtl/dsp_skid_ctrl.sv
module dsp_skid_ctrl
  import dsp_pkg::*;
#(
  parameter int NUM_THR    = 2,
  parameter int DISP_W     = 2,
  parameter int INST_W     = 8,
  parameter int SKID_DEPTH = 4,
  localparam int TID_W     = (NUM_THR > 1) ? $clog2(NUM_THR) : 1,
  localparam int IN_CW     = $clog2(DISP_W + 1)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [DISP_W-1:0]                 in_valid,
  input  logic [DISP_W*TID_W-1:0]           in_tid,
  input  logic [DISP_W-1:0]                 in_sq,
  input  logic [DISP_W*INST_W-1:0]          in_inst,
  input  logic [NUM_THR-1:0]                commit_stall,
  input  logic [NUM_THR-1:0]                iq_full,
  input  logic [NUM_THR-1:0]                lsq_full,
  input  logic [NUM_THR-1:0]                squash,
  output logic [NUM_THR*DISP_W-1:0]         out_valid,
  output logic [NUM_THR*DISP_W*INST_W-1:0]  out_inst,
  output logic [NUM_THR-1:0]                block_up,
  output logic [NUM_THR-1:0]                unblock_up,
  output logic [NUM_THR*3-1:0]              status
);

  logic [NUM_THR*DISP_W*INST_W-1:0] thr_inst;
  logic [NUM_THR*IN_CW-1:0]         thr_cnt;

  dsp_sort #(
    .NUM_THR(NUM_THR), .DISP_W(DISP_W), .INST_W(INST_W), .TID_W(TID_W)
  ) u_sort (
    .in_valid(in_valid), .in_tid(in_tid), .in_sq(in_sq), .in_inst(in_inst),
    .thr_inst(thr_inst), .thr_cnt(thr_cnt)
  );

  genvar t;
  generate
    for (t = 0; t < NUM_THR; t++) begin : g_lane
      dsp_state_e st;

      dsp_lane #(
        .DISP_W(DISP_W), .INST_W(INST_W), .SKID_DEPTH(SKID_DEPTH)
      ) u_lane (
        .clk       (clk),
        .rst       (rst),
        .inc_inst  (thr_inst[t*DISP_W*INST_W +: DISP_W*INST_W]),
        .inc_cnt   (thr_cnt[t*IN_CW +: IN_CW]),
        .stall     (commit_stall[t] | iq_full[t] | lsq_full[t]),
        .squash    (squash[t]),
        .out_valid (out_valid[t*DISP_W +: DISP_W]),
        .out_inst  (out_inst[t*DISP_W*INST_W +: DISP_W*INST_W]),
        .block_up  (block_up[t]),
        .unblock_up(unblock_up[t]),
        .state     (st)
      );

      assign status[t*3 +: 3] = st;
    end
  endgenerate

endmodule

// File: tb/sim_dsp_skid_ctrl.sv
module sim_dsp_skid_ctrl;

  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  in_valid, in_tid, in_sq;
  logic [15:0] in_inst;
  logic [1:0]  commit_stall, iq_full, lsq_full, squash;
  logic [3:0]  out_valid;
  logic [31:0] out_inst;
  logic [1:0]  block_up, unblock_up;
  logic [5:0]  status;

  int checks = 0;
  int errors = 0;

  always #(PERIOD/2) clk = ~clk;

  dsp_skid_ctrl #(.NUM_THR(2), .DISP_W(2), .INST_W(8), .SKID_DEPTH(4)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_tid(in_tid), .in_sq(in_sq),
    .in_inst(in_inst), .commit_stall(commit_stall), .iq_full(iq_full),
    .lsq_full(lsq_full), .squash(squash), .out_valid(out_valid),
    .out_inst(out_inst), .block_up(block_up), .unblock_up(unblock_up),
    .status(status)
  );

  typedef struct packed {
    logic [1:0] v; logic [1:0] sq; logic [1:0] tid;
    logic [7:0] i0; logic [7:0] i1;
    logic cst; logic iqf; logic lsf; logic sqh;
    logic [1:0] ov0; logic [7:0] o0; logic [7:0] o1;
    logic blk; logic ub; logic [2:0] st;
    logic [1:0] ov1; logic [7:0] o10;
  } row_t;

  localparam int NROW = 16;
  localparam row_t TBL [NROW] = '{
    '{2'b11,2'b00,2'b00,8'hA1,8'hA2,1'b0,1'b0,1'b0,1'b0, 2'b11,8'hA1,8'hA2,1'b0,1'b0,3'd0, 2'b00,8'h00},
    '{2'b00,2'b00,2'b00,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0, 2'b00,8'h00,8'h00,1'b0,1'b0,3'd2, 2'b00,8'h00},
    '{2'b11,2'b00,2'b00,8'hB1,8'hB2,1'b1,1'b0,1'b0,1'b0, 2'b00,8'h00,8'h00,1'b1,1'b0,3'd1, 2'b00,8'h00},
    '{2'b01,2'b00,2'b00,8'hB3,8'h00,1'b0,1'b1,1'b0,1'b0, 2'b00,8'h00,8'h00,1'b0,1'b0,3'd1, 2'b00,8'h00},
    '{2'b00,2'b00,2'b00,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0, 2'b11,8'hB1,8'hB2,1'b0,1'b0,3'd5, 2'b00,8'h00},
    '{2'b11,2'b00,2'b00,8'hC1,8'hC2,1'b0,1'b0,1'b0,1'b0, 2'b11,8'hB3,8'hC1,1'b0,1'b0,3'd5, 2'b00,8'h00},
    '{2'b00,2'b00,2'b00,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0, 2'b01,8'hC2,8'h00,1'b0,1'b1,3'd0, 2'b00,8'h00},
    '{2'b11,2'b01,2'b00,8'hD1,8'hD2,1'b0,1'b0,1'b0,1'b0, 2'b01,8'hD2,8'h00,1'b0,1'b0,3'd0, 2'b00,8'h00},
    '{2'b11,2'b00,2'b00,8'hE1,8'hE2,1'b0,1'b0,1'b1,1'b0, 2'b00,8'h00,8'h00,1'b1,1'b0,3'd1, 2'b00,8'h00},
    '{2'b11,2'b00,2'b00,8'hF1,8'hF2,1'b1,1'b0,1'b0,1'b1, 2'b00,8'h00,8'h00,1'b0,1'b1,3'd3, 2'b00,8'h00},
    '{2'b11,2'b00,2'b00,8'h31,8'h32,1'b0,1'b0,1'b0,1'b0, 2'b00,8'h00,8'h00,1'b0,1'b0,3'd4, 2'b00,8'h00},
    '{2'b00,2'b00,2'b00,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0, 2'b00,8'h00,8'h00,1'b0,1'b0,3'd2, 2'b00,8'h00},
    '{2'b11,2'b00,2'b00,8'h41,8'h42,1'b0,1'b0,1'b0,1'b0, 2'b11,8'h41,8'h42,1'b0,1'b0,3'd0, 2'b00,8'h00},
    '{2'b11,2'b00,2'b01,8'h71,8'h81,1'b0,1'b0,1'b0,1'b0, 2'b01,8'h81,8'h00,1'b0,1'b0,3'd0, 2'b01,8'h71},
    '{2'b11,2'b00,2'b11,8'h91,8'h92,1'b1,1'b0,1'b0,1'b0, 2'b00,8'h00,8'h00,1'b1,1'b0,3'd1, 2'b11,8'h91},
    '{2'b00,2'b00,2'b00,8'h00,8'h00,1'b0,1'b0,1'b0,1'b0, 2'b00,8'h00,8'h00,1'b0,1'b1,3'd0, 2'b00,8'h00}
  };
  localparam string TAG [NROW] = '{
    "R3", "R10", "R5", "R4", "R6", "R6", "R7", "R2",
    "R5", "R8", "R8", "R8", "R8", "R2", "R4", "R7"
  };

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic idle_in();
    in_valid = '0; in_tid = '0; in_sq = '0; in_inst = '0;
    commit_stall = '0; iq_full = '0; lsq_full = '0; squash = '0;
  endtask

  task automatic settle();
    @(posedge clk);
    #(PERIOD/4);
  endtask

  initial begin
    #(PERIOD*200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    idle_in();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    settle();
    // R1 reset state
    chk("R1", "status", 32'(status), 32'h12);
    chk("R1", "out_valid", 32'(out_valid), 32'h0);
    chk("R1", "pulses", 32'({block_up, unblock_up}), 32'h0);

    for (int r = 0; r < NROW; r++) begin
      @(negedge clk);
      in_valid = TBL[r].v; in_sq = TBL[r].sq; in_tid = TBL[r].tid;
      in_inst = {TBL[r].i1, TBL[r].i0};
      commit_stall = {1'b0, TBL[r].cst};
      iq_full = {1'b0, TBL[r].iqf};
      lsq_full = {1'b0, TBL[r].lsf};
      squash = {1'b0, TBL[r].sqh};
      settle();
      chk(TAG[r], "t0 valid", 32'(out_valid[1:0]), 32'(TBL[r].ov0));
      if (TBL[r].ov0[0]) chk(TAG[r], "t0 lane0", 32'(out_inst[7:0]), 32'(TBL[r].o0));
      if (TBL[r].ov0[1]) chk(TAG[r], "t0 lane1", 32'(out_inst[15:8]), 32'(TBL[r].o1));
      chk(TAG[r], "t0 block", 32'(block_up[0]), 32'(TBL[r].blk));
      chk(TAG[r], "t0 unblock", 32'(unblock_up[0]), 32'(TBL[r].ub));
      chk(TAG[r], "t0 status", 32'(status[2:0]), 32'(TBL[r].st));
      chk(TAG[r], "t1 valid", 32'(out_valid[3:2]), 32'(TBL[r].ov1));
      if (TBL[r].ov1[0]) chk(TAG[r], "t1 lane0", 32'(out_inst[23:16]), 32'(TBL[r].o10));
    end

    // R9: fill thread 1 to full depth, then drain without loss
    @(negedge clk);
    in_valid = 2'b11; in_tid = 2'b11; in_sq = 2'b00; in_inst = 16'h5251;
    commit_stall = '0; iq_full = 2'b10; lsq_full = '0; squash = '0;
    settle();
    chk("R5", "t1 block", 32'(block_up[1]), 32'h1);
    chk("R4", "t1 status", 32'(status[5:3]), 32'h1);
    @(negedge clk);
    in_inst = 16'h5453;
    settle();
    chk("R9", "t1 valid full", 32'(out_valid[3:2]), 32'h0);
    chk("R5", "t1 no repeat block", 32'(block_up[1]), 32'h0);
    @(negedge clk);
    idle_in();
    settle();
    chk("R6", "t1 drain1", 32'({out_valid[3:2], out_inst[31:16]}), 32'h35251);
    chk("R6", "t1 unblocking", 32'(status[5:3]), 32'h5);
    @(negedge clk);
    settle();
    chk("R9", "t1 drain2", 32'({out_valid[3:2], out_inst[31:16]}), 32'h35453);
    chk("R7", "t1 unblock", 32'(unblock_up[1]), 32'h1);
    chk("R7", "t1 running", 32'(status[5:3]), 32'h0);
    @(negedge clk);
    settle();
    chk("R9", "t1 nothing left", 32'(out_valid[3:2]), 32'h0);
    chk("R10", "t1 idle", 32'(status[5:3]), 32'h2);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule